// File: doc/BRIEF.md
# GPIO Register Bank with Clear/Set/Toggle Aliases

This block is the register file of a 16-pin general-purpose I/O port. A simple 16-bit bus with a byte address, write and read strobes, and an access-width flag reaches seventeen registers. They hold the port data, two interrupt mask words, pin direction, and the four interrupt-shaping words: polarity, edge select, both-edge select and input enable. The data word and both mask words each have three companion alias addresses. Writing a 1 to a bit at those addresses clears, sets or inverts that bit of the base word. Reading any alias returns the base word.

The block drives pin levels and output enables from the data and direction words. It merges sampled input levels into the data word on every cycle, for pins that are inputs and are enabled. It emits a one-cycle change pulse for each driven pin whose data bit moves. Interrupt detection is left to a neighbouring block, so the masks and the interrupt-shaping words are exported as plain outputs. Reads and error reporting are combinational and complete in the cycle of the access. Writes take effect at the clock edge that ends the access cycle.

Top module: `gpio_alias_bank`

## Requirements
- R1: After reset every register reads zero, and pin_oe, pin_out, pin_chg and all exported configuration words are zero.
- R2: Registers sit at byte offsets index*4. The register order is data, data-clear, data-set, data-toggle (0x00..0x0C), mask A and its clear/set/toggle aliases (0x10..0x1C), mask B and its aliases (0x20..0x2C), direction 0x30, polarity 0x34, edge 0x38, both-edge 0x3C and input-enable 0x40. A write to a base or configuration address replaces the whole word.
- R3: A write to a clear alias (offset 0x04 within a group) clears each bit of the base word where the written value holds a 1 and keeps the other bits.
- R4: A write to a set alias (offset 0x08 within a group) ORs the written value into the base word.
- R5: A write to a toggle alias (offset 0x0C within a group) XORs the written value into the base word.
- R6: A read of any clear, set or toggle alias returns the current value of its base word.
- R7: An access is invalid if bus_wide is 0, if the two low address bits are nonzero, or if the offset is above 0x40. An invalid access raises bus_err in the same cycle, returns zero, and changes no register. A valid access keeps bus_err low.
- R8: pin_oe equals the direction word. pin_out carries the data bit for pins whose direction bit is 1 and is 0 elsewhere.
- R9: On each clock edge, data bit i takes pin_in[i] if direction bit i is 0 and input-enable bit i is 1, both taken before that edge. Other data bits do not follow pin_in.
- R10: When a bus write to the data word or its aliases coincides with the input update, the enabled input bits take pin_in and all other bits take the bus result.
- R11: pin_chg[i] is high for exactly the one cycle after an edge at which data bit i changed, and only if direction bit i is 1. A write that leaves a bit unchanged raises no pulse.
- R12: irq_mask_a, irq_mask_b, cfg_polar, cfg_edge, cfg_both and cfg_inen always equal their registers as read over the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wide | input | 1 | 1 for a 16-bit access; 0 marks a narrow, illegal access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, combinational |
| bus_err | output | 1 | Invalid access flag, combinational |
| pin_in | input | W | Sampled input pin levels |
| pin_out | output | W | Output pin levels |
| pin_oe | output | W | Output enables |
| pin_chg | output | W | One-cycle pulse per driven pin whose data bit changed |
| irq_mask_a | output | W | Interrupt mask A word |
| irq_mask_b | output | W | Interrupt mask B word |
| cfg_polar | output | W | Polarity word |
| cfg_edge | output | W | Edge select word |
| cfg_both | output | W | Both-edge select word |
| cfg_inen | output | W | Input enable word |

## Verification
The bench drives each alias against a base value chosen so that clear, set and toggle all produce different words. A design that routed an alias to the wrong operation or the wrong group, or that stored the alias as its own register, would read back a wrong value at the base or at the alias. Invalid accesses cover a narrow write to a live mask address, a misaligned read and the first address past the map. A design that decoded these partly would change the mask or return non-zero data. The input merge is tested with a mixed direction and enable pattern, and then a data write is made while an enabled input pin is held at 0. A design that let the bus override the pin, or let disabled pins follow, would show the wrong bits. Change pulses are checked for a toggle that touches a driven pin and an undriven one, and for a rewrite of the same value.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Low two bits of the register index inside a data/mask group.
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_CLEAR = 2'd1,
    OP_SET   = 2'd2,
    OP_FLIP  = 2'd3
  } alias_op_e;

  localparam int NGRP      = 3;  // data, mask A, mask B
  localparam int NCFG      = 5;  // dir, polar, edge, both, inen
  localparam int NREG      = NGRP * 4 + NCFG;
  localparam int FIRST_CFG = NGRP * 4;

  localparam int CFG_DIR   = 0;
  localparam int CFG_POLAR = 1;
  localparam int CFG_EDGE  = 2;
  localparam int CFG_BOTH  = 3;
  localparam int CFG_INEN  = 4;

  // Result of a bus write through one of the four addresses of a group.
  function automatic logic [15:0] alias_apply(input logic [15:0] cur,
                                              input logic [15:0] wv,
                                              input alias_op_e  op);
    logic [15:0] r;
    unique case (op)
      OP_WRITE: r = wv;
      OP_CLEAR: r = cur & ~wv;
      OP_SET:   r = cur | wv;
      OP_FLIP:  r = cur ^ wv;
      default:  r = cur;
    endcase
    return r;
  endfunction

  // Enabled input bits take the pin level, the rest keep the bus result.
  function automatic logic [15:0] merge_pins(input logic [15:0] busv,
                                             input logic [15:0] mask,
                                             input logic [15:0] pins);
    return (busv & ~mask) | (pins & mask);
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode #(
  parameter int ADDR_W = 7,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  input  logic              wr,
  input  logic              rd,
  output logic              acc_ok,
  output logic              acc_bad,
  output logic [IDX_W-1:0]  idx
);
  import gpio_bank_pkg::*;

  logic in_range;
  logic aligned;

  assign idx      = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_range = (32'(idx) < NREG);
  assign acc_ok   = wide && aligned && in_range;
  assign acc_bad  = (wr || rd) && !acc_ok;

endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg #(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  gpio_bank_pkg::alias_op_e op,
  input  logic [W-1:0]             wdata,
  input  logic [W-1:0]             ext_mask,
  input  logic [W-1:0]             ext_val,
  output logic [W-1:0]             q
);
  import gpio_bank_pkg::*;

  logic [W-1:0] bus_next;
  logic [W-1:0] q_next;

  always_comb begin
    bus_next = wr_en ? alias_apply(q, wdata, op) : q;
    q_next   = merge_pins(bus_next, ext_mask, ext_val);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_CLEAR) |=>
      ((q & ~$past(ext_mask)) == ($past(q) & ~$past(wdata) & ~$past(ext_mask))));

  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_SET) |=>
      ((q & ~$past(ext_mask)) == (($past(q) | $past(wdata)) & ~$past(ext_mask))));

  assert_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_FLIP) |=>
      ((q & ~$past(ext_mask)) == (($past(q) ^ $past(wdata)) & ~$past(ext_mask))));

  assert_pin_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_mask) |=> (((q ^ $past(ext_val)) & $past(ext_mask)) == '0));

endmodule

// File: rtl/gpio_out_track.sv
module gpio_out_track #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data,
  input  logic [W-1:0] dir,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_chg
);
  logic [W-1:0] data_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) data_prev <= '0;
    else        data_prev <= data;
  end

  assign pin_oe  = dir;
  assign pin_out = data & dir;
  assign pin_chg = (data ^ data_prev) & dir;

  assert_chg_needs_move_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_chg) |=> ($past(pin_chg) & ($past(data) ^ $past(data_prev))) == $past(pin_chg));

  assert_chg_only_driven_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_chg & ~pin_oe) == '0));

endmodule

// File: rtl/gpio_alias_bank.sv
module gpio_alias_bank #(
  parameter int W      = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wide,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              bus_err,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pin_chg,
  output logic [W-1:0]      irq_mask_a,
  output logic [W-1:0]      irq_mask_b,
  output logic [W-1:0]      cfg_polar,
  output logic [W-1:0]      cfg_edge,
  output logic [W-1:0]      cfg_both,
  output logic [W-1:0]      cfg_inen
);
  import gpio_bank_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic             acc_ok;
  logic             acc_bad;
  logic [IDX_W-1:0] idx;
  logic             wr_ok;
  logic             is_grp;
  logic [1:0]       grp_sel;
  logic [2:0]       cfg_sel;
  alias_op_e        op;
  logic [W-1:0]     grp_q [NGRP];
  logic [W-1:0]     cfg_q [NCFG];
  logic [NGRP-1:0]  grp_wr;
  logic [W-1:0]     in_mask;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .wide   (bus_wide),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .acc_ok (acc_ok),
    .acc_bad(acc_bad),
    .idx    (idx)
  );

  assign wr_ok   = bus_wr && acc_ok;
  assign is_grp  = (32'(idx) < FIRST_CFG);
  assign grp_sel = idx[3:2];
  assign cfg_sel = 3'(32'(idx) - FIRST_CFG);
  assign op      = alias_op_e'(idx[1:0]);
  assign in_mask = ~cfg_q[CFG_DIR] & cfg_q[CFG_INEN];

  // Data and the two mask words, each with three alias addresses.
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [W-1:0] ext_m;
    logic [W-1:0] ext_v;
    assign grp_wr[g] = wr_ok && is_grp && (grp_sel == 2'(g));
    if (g == 0) begin : g_pins
      assign ext_m = in_mask;
      assign ext_v = pin_in;
    end else begin : g_nopins
      assign ext_m = '0;
      assign ext_v = '0;
    end
    gpio_alias_reg #(.W(W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (grp_wr[g]),
      .op      (op),
      .wdata   (bus_wdata),
      .ext_mask(ext_m),
      .ext_val (ext_v),
      .q       (grp_q[g])
    );
  end

  // Plain configuration words.
  for (genvar c = 0; c < NCFG; c++) begin : g_cfg
    logic sel;
    assign sel = wr_ok && !is_grp && (cfg_sel == 3'(c));
    always_ff @(posedge clk) begin
      if (!rst_n)   cfg_q[c] <= '0;
      else if (sel) cfg_q[c] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (acc_ok && bus_rd) begin
      if (is_grp) bus_rdata = grp_q[grp_sel];
      else        bus_rdata = cfg_q[cfg_sel];
    end
  end
  assign bus_err = acc_bad;

  gpio_out_track #(.W(W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .data   (grp_q[0]),
    .dir    (cfg_q[CFG_DIR]),
    .pin_out(pin_out),
    .pin_oe (pin_oe),
    .pin_chg(pin_chg)
  );

  assign irq_mask_a = grp_q[1];
  assign irq_mask_b = grp_q[2];
  assign cfg_polar  = cfg_q[CFG_POLAR];
  assign cfg_edge   = cfg_q[CFG_EDGE];
  assign cfg_both   = cfg_q[CFG_BOTH];
  assign cfg_inen   = cfg_q[CFG_INEN];

  assert_err_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

  assert_err_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> ($stable(irq_mask_a) && $stable(irq_mask_b) && $stable(pin_oe) &&
                 $stable(cfg_polar) && $stable(cfg_edge) && $stable(cfg_both) &&
                 $stable(cfg_inen)));

  assert_idle_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_wr[0] |=> (((grp_q[0] ^ $past(grp_q[0])) & ~$past(in_mask)) == '0));

endmodule

// File: tb/gpio_alias_bank_tb_top.sv
module gpio_alias_bank_tb_top;
  localparam int W = 16;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wide = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          bus_err;
  logic [W-1:0]  pin_in = '0;
  logic [W-1:0]  pin_out, pin_oe, pin_chg;
  logic [W-1:0]  irq_mask_a, irq_mask_b, cfg_polar, cfg_edge, cfg_both, cfg_inen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_alias_bank #(.W(W), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wide(bus_wide),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_chg(pin_chg),
    .irq_mask_a(irq_mask_a), .irq_mask_b(irq_mask_b), .cfg_polar(cfg_polar),
    .cfg_edge(cfg_edge), .cfg_both(cfg_both), .cfg_inen(cfg_inen)
  );

  // Byte offsets
  localparam logic [AW-1:0] A_DATA = 7'h00, A_DCLR = 7'h04, A_DSET = 7'h08, A_DTGL = 7'h0C;
  localparam logic [AW-1:0] A_MA = 7'h10, A_MACLR = 7'h14, A_MASET = 7'h18, A_MATGL = 7'h1C;
  localparam logic [AW-1:0] A_MB = 7'h20, A_MBCLR = 7'h24, A_MBSET = 7'h28, A_MBTGL = 7'h2C;
  localparam logic [AW-1:0] A_DIR = 7'h30, A_POL = 7'h34, A_EDG = 7'h38, A_BOTH = 7'h3C, A_INEN = 7'h40;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, the write lands on the next posedge, return at the following negedge.
  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] v, input logic wide = 1'b1);
    bus_addr = a; bus_wdata = v; bus_wide = wide; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wide = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] v, output logic e);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    v = bus_rdata; e = bus_err;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [W-1:0] exp);
    logic [W-1:0] v; logic e;
    rd(a, v, e);
    chk(req, {16'h0, v}, {16'h0, exp});
    chk(req, {31'h0, e}, 32'h0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 17; i++) rd_chk("R1 reset read", AW'(i * 4), 16'h0000);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_chg", pin_chg, 0);
    chk("R1 exports", {irq_mask_a, irq_mask_b}, 0);
    chk("R1 exports cfg", {cfg_polar, cfg_edge}, 0);
    chk("R1 exports cfg2", {cfg_both, cfg_inen}, 0);
  endtask

  task automatic t_plain;
    wr(A_POL, 16'h1111); wr(A_EDG, 16'h2222); wr(A_BOTH, 16'h4444);
    wr(A_INEN, 16'h8888); wr(A_MB, 16'h0F0F);
    wr(A_POL, 16'h1357);  // replace whole word
    rd_chk("R2 polar replace", A_POL, 16'h1357);
    rd_chk("R2 edge", A_EDG, 16'h2222);
    rd_chk("R2 both", A_BOTH, 16'h4444);
    rd_chk("R2 inen", A_INEN, 16'h8888);
    chk("R12 cfg_polar", cfg_polar, 16'h1357);
    chk("R12 cfg_edge", cfg_edge, 16'h2222);
    chk("R12 cfg_both", cfg_both, 16'h4444);
    chk("R12 cfg_inen", cfg_inen, 16'h8888);
    chk("R12 irq_mask_b", irq_mask_b, 16'h0F0F);
    wr(A_INEN, 16'h0000);
  endtask

  task automatic t_alias;
    wr(A_MA, 16'hF0F0);
    wr(A_MACLR, 16'h3030);
    rd_chk("R3 maskA clear", A_MA, 16'hC0C0);
    wr(A_MASET, 16'h000F);
    rd_chk("R4 maskA set", A_MA, 16'hC0CF);
    wr(A_MATGL, 16'hFFFF);
    rd_chk("R5 maskA toggle", A_MA, 16'h3F30);
    rd_chk("R6 maskA via clear", A_MACLR, 16'h3F30);
    rd_chk("R6 maskA via set", A_MASET, 16'h3F30);
    rd_chk("R6 maskA via toggle", A_MATGL, 16'h3F30);
    chk("R12 irq_mask_a", irq_mask_a, 16'h3F30);
    wr(A_MBCLR, 16'h0003); wr(A_MBSET, 16'h8000); wr(A_MBTGL, 16'h00F0);
    rd_chk("R3 R4 R5 maskB", A_MBTGL, 16'h8FFC);
    wr(A_DATA, 16'hAAAA);
    wr(A_DCLR, 16'h000A);
    rd_chk("R3 data clear", A_DTGL, 16'hAAA0);
    wr(A_DSET, 16'h0005);
    rd_chk("R4 data set", A_DCLR, 16'hAAA5);
    wr(A_DTGL, 16'hFF00);
    rd_chk("R5 R6 data toggle", A_DSET, 16'h55A5);
  endtask

  task automatic t_invalid;
    logic [W-1:0] v; logic e;
    wr(A_MA, 16'hFFFF, 1'b0);  // narrow write
    rd_chk("R7 narrow write ignored", A_MA, 16'h3F30);
    bus_addr = A_MA; bus_wide = 1'b0; bus_wr = 1'b1; bus_wdata = 16'h1234;
    #1; chk("R7 narrow err", {31'h0, bus_err}, 1);
    @(negedge clk); bus_wr = 1'b0; bus_wide = 1'b1;
    rd(7'h44, v, e);
    chk("R7 past-end err", {31'h0, e}, 1);
    chk("R7 past-end zero", {16'h0, v}, 0);
    rd(7'h12, v, e);
    chk("R7 misaligned err", {31'h0, e}, 1);
    chk("R7 misaligned zero", {16'h0, v}, 0);
    wr(7'h44, 16'hFFFF);
    rd_chk("R7 past-end write no effect", A_MA, 16'h3F30);
    rd_chk("R7 polar kept", A_POL, 16'h1357);
  endtask

  task automatic t_output;
    wr(A_DIR, 16'h00FF);
    wr(A_DATA, 16'h1234);
    @(negedge clk);
    chk("R8 pin_oe", pin_oe, 16'h00FF);
    chk("R8 pin_out", pin_out, 16'h0034);
    chk("R11 idle no pulse", pin_chg, 0);
    wr(A_DTGL, 16'h0101);
    chk("R11 toggle pulse driven only", pin_chg, 16'h0001);
    @(negedge clk);
    chk("R11 pulse one cycle", pin_chg, 0);
    wr(A_DATA, 16'h1335);
    chk("R11 same value no pulse", pin_chg, 0);
  endtask

  task automatic t_input;
    wr(A_INEN, 16'h0F0F);  // enabled inputs = ~dir & inen = 0x0F00
    pin_in = 16'hFFFF;
    @(negedge clk); @(negedge clk);
    rd_chk("R9 enabled inputs follow", A_DATA, 16'h1F35);
    pin_in = 16'h0000;
    @(negedge clk);
    rd_chk("R9 enabled inputs fall", A_DATA, 16'h1035);
  endtask

  task automatic t_collide;
    wr(A_DATA, 16'hFFFF);  // pin_in held 0
    rd_chk("R10 pin wins on enabled bits", A_DATA, 16'hF0FF);
    chk("R10 R8 pin_out", pin_out, 16'h00FF);
    wr(A_DTGL, 16'h0F00);
    rd_chk("R10 toggle on enabled bits", A_DATA, 16'hF0FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_plain;
    t_alias;
    t_invalid;
    t_output;
    t_input;
    t_collide;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule